// File: doc/BRIEF.md
# Reconfigurable Set-Associative Read Cache

This block is a read-only cache built on four physical ways of 16-byte lines. Three configuration fields reshape it at run time. The associativity field folds ways into index bits, so the same storage acts as 4-way, 2-way or direct-mapped. The way-enable mask switches individual ways off. The line-size field makes one miss fill one, two or four consecutive physical lines, giving 16, 32 or 64 byte lines. A fourth bit turns on a most-recently-used way predictor.

A processor issues word reads with a valid/ready handshake. It receives a one-cycle response pulse carrying a hit flag and the data word. Misses are refilled one word at a time from a memory port with an acknowledge. Every physical line stores its full line address as its tag. After a configuration change, lines filed under the old mapping therefore simply fail the tag compare. Nothing is flushed, and lines that become reachable again still hit.

Top module: `reconfig_cache`

## Requirements
- R1: A request is accepted only while `cpuReady` is high (idle). Without prediction, a hit raises `rspValid` with `rspHit`=1 for one cycle, on the first clock edge after acceptance, and `rspData` carries the stored word.
- R2: On a miss the block reads the whole logical line from memory, one word per acknowledged cycle, in ascending word-address order. It then pulses `rspValid` with `rspHit`=0 and the requested word in `rspData`. With a 16-byte line and no stalls, the response comes 5 edges after acceptance. While refilling, `memReq` is high and `cpuReady` is low.
- R3: `cfgIn[3:2]` selects the line size: 0 means 16 B, 1 means 32 B and 2 means 64 B. A miss fills the aligned group of 1, 2 or 4 consecutive physical lines, all into the same way. The miss latency is 1+4·lines edges, and every line of the group hits afterwards.
- R4: `cfgIn[1:0]` selects the associativity, where the line address is the word address without its two low bits. Code 0 is 4-way: all ways are candidates. Code 1 is 2-way: ways {0,1} are candidates when line-address bit 2 is 0, and ways {2,3} when it is 1. Code 2 is direct-mapped: only the way numbered by line-address bits [3:2] is a candidate.
- R5: `cfgIn[7:4]` enables ways, with bit 4+w enabling way w. A disabled way never hits and is never filled, but it keeps its contents, which hit again once the way is re-enabled.
- R6: When no candidate way is enabled, a miss is still served from memory but nothing is allocated.
- R7: The victim is the first enabled candidate found by scanning upward, cyclically, from a per-set round-robin pointer. That pointer is indexed by the requested set and then moves to one past the victim.
- R8: With `cfgIn[8]`=1, only the set's most-recently-used way is probed first. A correct prediction responds in 1 edge and a wrong one in 2. A miss costs 1 extra edge on top of the R2 timing.
- R9: The configuration is captured only at acceptance. Changes to `cfgIn` during an access have no effect on that access, and changing the configuration never erases stored lines.
- R10: After reset, `cpuReady` is 1 and `rspValid` and `memReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuValid | input | 1 | Read request |
| cpuAddr | input | ADDR_W | Word address of the read |
| cfgIn | input | 9 | {predict, wayEnable[3:0], lineSize[1:0], assoc[1:0]} |
| cpuReady | output | 1 | Idle, request may be accepted |
| rspValid | output | 1 | One-cycle response pulse |
| rspHit | output | 1 | Response came from the cache |
| rspData | output | DATA_W | Read data |
| memReq | output | 1 | Refill word request |
| memAddr | output | ADDR_W | Word address being refilled |
| memAck | input | 1 | Memory data valid for memAddr |
| memData | input | DATA_W | Refill data |

## Verification
The bench keeps the default four sets per way and four words per line. This way a 64-byte fill spans every set of one way, and each set address can be driven into eviction by hand through a short sequence. With only four sets, round-robin pointers, predictor state and stale-mapping misses can all be followed exactly across configuration changes. A stalled acknowledge and a mid-refill configuration change are reachable in a single access.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int NWAYS = 4;

  typedef enum logic [1:0] {ASSOC4 = 2'd0, ASSOC2 = 2'd1, ASSOC1 = 2'd2} assocE;
  typedef enum logic [1:0] {LINE16 = 2'd0, LINE32 = 2'd1, LINE64 = 2'd2} lineE;

  typedef struct packed {
    logic       predEn;
    logic [3:0] wayOn;
    lineE       lineSz;
    assocE      assoc;
  } cfgT;

  localparam int CFG_W = $bits(cfgT);

  typedef struct packed {
    logic capture;
    logic hitLoad;
    logic fillWr;
    logic finish;
  } ctlT;
endpackage

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int SET_W  = 2,
  parameter int WORD_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [CFG_W-1:0]  cfgIn,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              fullHit,
  output logic              predHit,
  output logic              predEn,
  output logic              refLast,
  output logic [DATA_W-1:0] rspData,
  output logic [NWAYS-1:0]  hitWays,
  output logic [NWAYS-1:0]  fillWays,
  output logic [NWAYS-1:0]  wayOn
);
  localparam int LINE_W = ADDR_W - WORD_W;
  localparam int SETS   = 1 << SET_W;
  localparam int WORDS  = 1 << WORD_W;
  localparam int CNT_W  = WORD_W + 2;

  logic [ADDR_W-1:0] reqQ;
  cfgT               cfgQ;
  logic [CNT_W-1:0]  cntQ;
  logic [SETS-1:0]   validQ [NWAYS];
  logic [LINE_W-1:0] tagQ   [NWAYS][SETS];
  logic [DATA_W-1:0] dataQ  [NWAYS][SETS][WORDS];
  logic [1:0]        mruQ   [SETS];
  logic [1:0]        rrQ    [SETS];

  logic [LINE_W-1:0] lineAddr, groupBase, fillLine;
  logic [WORD_W-1:0] wordIdx, fillWord;
  logic [SET_W-1:0]  setIdx, fillSet;
  logic [1:0]        wsel, grpMask, hitIdx, victim, scanWay;
  logic [NWAYS-1:0]  cand;
  logic [DATA_W-1:0] hitData;
  logic              allocOk, found;

  assign lineAddr = reqQ[ADDR_W-1:WORD_W];
  assign wordIdx  = reqQ[WORD_W-1:0];
  assign setIdx   = lineAddr[SET_W-1:0];
  assign wsel     = lineAddr[SET_W+1:SET_W];
  assign predEn   = cfgQ.predEn;
  assign wayOn    = cfgQ.wayOn;

  always_comb begin
    unique case (cfgQ.assoc)
      ASSOC4:  cand = 4'b1111;
      ASSOC2:  cand = wsel[0] ? 4'b1100 : 4'b0011;
      default: cand = 4'b0001 << wsel;
    endcase
    cand    = cand & cfgQ.wayOn;
    allocOk = |cand;
  end

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign hitWays[w] = cand[w] && validQ[w][setIdx] && (tagQ[w][setIdx] == lineAddr);
  end

  always_comb begin
    hitData = '0;
    hitIdx  = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (hitWays[w]) begin
        hitData = dataQ[w][setIdx][wordIdx];
        hitIdx  = 2'(w);
      end
    end
    fullHit = |hitWays;
    predHit = hitWays[mruQ[setIdx]];
  end

  always_comb begin
    victim  = rrQ[setIdx];
    found   = 1'b0;
    scanWay = '0;
    for (int i = 0; i < NWAYS; i++) begin
      scanWay = rrQ[setIdx] + 2'(i);
      if (!found && cand[scanWay]) begin
        victim = scanWay;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (cfgQ.lineSz)
      LINE16:  grpMask = 2'b00;
      LINE32:  grpMask = 2'b01;
      default: grpMask = 2'b11;
    endcase
    groupBase = lineAddr & ~{{(LINE_W-2){1'b0}}, grpMask};
    fillLine  = groupBase | {{(LINE_W-2){1'b0}}, cntQ[CNT_W-1:WORD_W]};
    fillWord  = cntQ[WORD_W-1:0];
    fillSet   = fillLine[SET_W-1:0];
    memAddr   = {fillLine, fillWord};
    refLast   = (cntQ[CNT_W-1:WORD_W] == grpMask) && (&fillWord);
    fillWays  = (ctl.fillWr && allocOk) ? (4'b0001 << victim) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= '0;
      cfgQ <= '0;
      cntQ <= '0;
      for (int w = 0; w < NWAYS; w++) validQ[w] <= '0;
      for (int s = 0; s < SETS; s++) begin
        mruQ[s] <= '0;
        rrQ[s]  <= '0;
      end
    end else begin
      if (ctl.capture) begin
        reqQ <= cpuAddr;
        cfgQ <= cfgT'(cfgIn);
        cntQ <= '0;
      end
      if (ctl.fillWr) begin
        cntQ <= cntQ + 1'b1;
        if (allocOk && (&fillWord)) validQ[victim][fillSet] <= 1'b1;
      end
      if (ctl.hitLoad) mruQ[setIdx] <= hitIdx;
      if (ctl.finish && allocOk) begin
        mruQ[setIdx] <= victim;
        rrQ[setIdx]  <= victim + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillWr && allocOk) begin
      dataQ[victim][fillSet][fillWord] <= memData;
      if (&fillWord) tagQ[victim][fillSet] <= fillLine;
    end
    if (ctl.hitLoad) rspData <= hitData;
    else if (ctl.fillWr && (memAddr == reqQ)) rspData <= memData;
  end
endmodule

// File: rtl/rcc_control.sv
module rcc_control
  import rcc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cpuValid,
  input  logic memAck,
  input  logic fullHit,
  input  logic predHit,
  input  logic predEn,
  input  logic refLast,
  output logic cpuReady,
  output logic memReq,
  output logic rspValid,
  output logic rspHit,
  output ctlT  ctl
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_PROBE, S_FILL} stateE;
  stateE st, nxt;

  always_comb begin
    ctl      = '0;
    nxt      = st;
    cpuReady = (st == S_IDLE);
    memReq   = (st == S_FILL);
    unique case (st)
      S_IDLE: if (cpuValid) begin
        ctl.capture = 1'b1;
        nxt = S_LOOK;
      end
      S_LOOK: begin
        if (predEn ? predHit : fullHit) begin
          ctl.hitLoad = 1'b1;
          nxt = S_IDLE;
        end else begin
          nxt = predEn ? S_PROBE : S_FILL;
        end
      end
      S_PROBE: begin
        if (fullHit) begin
          ctl.hitLoad = 1'b1;
          nxt = S_IDLE;
        end else begin
          nxt = S_FILL;
        end
      end
      default: if (memAck) begin
        ctl.fillWr = 1'b1;
        if (refLast) begin
          ctl.finish = 1'b1;
          nxt = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= S_IDLE;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      st       <= nxt;
      rspValid <= ctl.hitLoad || ctl.finish;
      rspHit   <= ctl.hitLoad;
    end
  end
endmodule

// File: rtl/reconfig_cache.sv
module reconfig_cache
  import rcc_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int SET_W  = 2,
  parameter int WORD_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [CFG_W-1:0]  cfgIn,
  output logic              cpuReady,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData
);
  ctlT              ctl;
  logic             fullHit, predHit, predEn, refLast;
  logic [NWAYS-1:0] hitWays, fillWays, wayOn;

  rcc_control u_ctl (
    .clk, .rstN, .cpuValid, .memAck, .fullHit, .predHit, .predEn, .refLast,
    .cpuReady, .memReq, .rspValid, .rspHit, .ctl
  );

  rcc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W), .WORD_W(WORD_W)) u_dp (
    .clk, .rstN, .ctl, .cpuAddr, .cfgIn, .memData, .memAddr, .fullHit, .predHit,
    .predEn, .refLast, .rspData, .hitWays, .fillWays, .wayOn
  );
endmodule

// File: rtl/reconfig_cache_checker.sv
module reconfig_cache_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cpuReady,
  input logic       rspValid,
  input logic       memReq,
  input logic [3:0] hitWays,
  input logic [3:0] fillWays,
  input logic [3:0] wayOn
);
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN) rspValid |=> !rspValid); // R1
  AST_REFILL_BUSY: assert property (@(posedge clk) disable iff (!rstN) memReq |-> !cpuReady); // R2
  AST_NO_HIT_OFF_WAY: assert property (@(posedge clk) disable iff (!rstN) (hitWays & ~wayOn) == 4'b0000); // R5
  AST_NO_FILL_OFF_WAY: assert property (@(posedge clk) disable iff (!rstN) (fillWays & ~wayOn) == 4'b0000); // R5
  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rstN) $onehot0(fillWays)); // R7
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN) !cpuReady |=> $stable(wayOn)); // R9
endmodule

bind reconfig_cache reconfig_cache_checker u_checker (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .rspValid(rspValid), .memReq(memReq),
  .hitWays(hitWays), .fillWays(fillWays), .wayOn(wayOn)
);

// File: tb/reconfig_cache_bench.sv
`timescale 1ns/1ps
module reconfig_cache_bench;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 32;
  localparam int NV = 27;
  localparam logic [8:0] CA = 9'h0F0, CB = 9'h0F8, CC = 9'h0F4, CD = 9'h0F2,
                         CE = 9'h0E2, CF = 9'h030, CG = 9'h0F1, CH = 9'h1F0;
  // {cfg, byte address, expected hit, expected latency in edges}
  localparam logic [33:0] VEC [NV] = '{
    {CA, 16'h0100, 1'b0, 8'd5},  {CA, 16'h0104, 1'b1, 8'd1},
    {CA, 16'h0200, 1'b0, 8'd5},  {CA, 16'h0100, 1'b1, 8'd1},
    {CB, 16'h1000, 1'b0, 8'd17}, {CB, 16'h1030, 1'b1, 8'd1},
    {CB, 16'h0200, 1'b1, 8'd1},  {CC, 16'h2010, 1'b0, 8'd9},
    {CC, 16'h2000, 1'b1, 8'd1},  {CC, 16'h0100, 1'b0, 8'd9},
    {CD, 16'h1030, 1'b0, 8'd5},  {CD, 16'h1030, 1'b1, 8'd1},
    {CE, 16'h1030, 1'b0, 8'd5},  {CA, 16'h1030, 1'b1, 8'd1},
    {CF, 16'h1000, 1'b0, 8'd5},  {CF, 16'h1010, 1'b0, 8'd5},
    {CA, 16'h1020, 1'b1, 8'd1},  {CG, 16'h0100, 1'b0, 8'd5},
    {CG, 16'h0100, 1'b1, 8'd1},  {CG, 16'h0040, 1'b0, 8'd5},
    {CG, 16'h0080, 1'b0, 8'd5},  {CG, 16'h0100, 1'b1, 8'd1},
    {CH, 16'h0080, 1'b1, 8'd2},  {CH, 16'h0080, 1'b1, 8'd1},
    {CH, 16'h0100, 1'b1, 8'd2},  {CH, 16'h0200, 1'b0, 8'd6},
    {CH, 16'h0200, 1'b1, 8'd1}
  };
  localparam string TAGS [NV] = '{
    "R2", "R1", "R2", "R1", "R3", "R3", "R9", "R3", "R3", "R7",
    "R4", "R4", "R6", "R9", "R5", "R5", "R5", "R4", "R4", "R4",
    "R7", "R7", "R8", "R8", "R8", "R8", "R8"
  };

  logic clk = 1'b0;
  logic rstN, cpuValid, cpuReady, rspValid, rspHit, memReq, memAck, ackOn;
  logic [ADDR_W-1:0] cpuAddr, memAddr;
  logic [8:0] cfgIn;
  logic [DATA_W-1:0] rspData, memData;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DATA_W-1:0] memF(input logic [ADDR_W-1:0] w);
    return {w ^ 14'h1A5A, 4'hC, w};
  endfunction

  assign memData = memF(memAddr);
  assign memAck  = memReq && ackOn;

  reconfig_cache u_reconfig_cache (
    .clk, .rstN, .cpuValid, .cpuAddr, .cfgIn, .cpuReady, .rspValid, .rspHit,
    .rspData, .memReq, .memAddr, .memAck, .memData
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // stall: drop memAck for three edges and change cfgIn mid-access
  task automatic access(input logic [8:0] cfg, input logic [15:0] byteAddr,
                        input bit stall, output bit hit, output logic [DATA_W-1:0] data,
                        output int lat);
    @(negedge clk);
    cfgIn = cfg; cpuAddr = byteAddr[15:2]; cpuValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpuValid = 1'b0;
    lat = 0;
    while (lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (stall && lat == 3) begin
        ackOn = 1'b0; cfgIn = CA;
        check(cpuReady == 1'b0, "R2", "ready while busy", longint'(cpuReady), 0);
      end
      if (stall && lat == 6) ackOn = 1'b1;
      if (rspValid) break;
    end
    hit = rspHit; data = rspData;
  endtask

  initial begin
    bit h;
    logic [DATA_W-1:0] d;
    int lat;
    rstN = 1'b0; cpuValid = 1'b0; cpuAddr = '0; cfgIn = CA; ackOn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuReady == 1'b1, "R10", "reset ready", longint'(cpuReady), 1);
    check(rspValid == 1'b0, "R10", "reset rspValid", longint'(rspValid), 0);
    check(memReq == 1'b0, "R10", "reset memReq", longint'(memReq), 0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      access(v[33:25], v[24:9], 1'b0, h, d, lat);
      check(h == v[8], TAGS[i], $sformatf("vector %0d hit", i), longint'(h), longint'(v[8]));
      check(lat == int'(v[7:0]), TAGS[i], $sformatf("vector %0d latency", i),
            longint'(lat), longint'(v[7:0]));
      check(d == memF(v[24:11]), TAGS[i], $sformatf("vector %0d data", i),
            longint'(d), longint'(memF(v[24:11])));
    end

    // R9: 64-byte miss with a config change and memory stall in flight
    access(CB, 16'h3008, 1'b1, h, d, lat);
    check(h == 1'b0, "R9", "stalled miss hit", longint'(h), 0);
    check(lat == 20, "R9", "stalled miss latency", longint'(lat), 20);
    check(d == memF(14'h0C02), "R9", "stalled miss data", longint'(d), longint'(memF(14'h0C02)));
    access(CA, 16'h3034, 1'b0, h, d, lat);
    check(h == 1'b1 && lat == 1, "R9", "group still filled", longint'({h, lat[7:0]}), 64'h101);
    check(d == memF(14'h0C0D), "R3", "group tail data", longint'(d), longint'(memF(14'h0C0D)));
    access(CA, 16'h3010, 1'b0, h, d, lat);
    check(h == 1'b1, "R3", "group second line", longint'(h), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule